// File: doc/BRIEF.md
# Dimension-Order Mesh Route Computer

This block makes the routing decision for one switch of a two-dimensional mesh with a parameterised radix. A packet header supplies the destination coordinates. The switch supplies its own coordinates. The block returns one of five output ports: east (+X), west (-X), north (+Y), south (-Y) or local ejection. It also returns the remaining hop counts that the header should carry onward.

Routing is deterministic, minimal and oblivious. The signed difference between destination and own coordinate gives the direction and the distance in each dimension. The X distance is used up completely before any Y hop is taken. Because channels are therefore always acquired in a fixed dimension order, no cyclic wait can form.

A header enters through a valid/ready handshake. The decision leaves through a single registered stage with its own valid/ready pair.

Top module: `dor_route_unit`

## Requirements
- R1: When the destination X differs from the own X, the port is +X (code 1) when the destination X is larger and -X (code 2) when it is smaller.
- R2: A Y port is chosen only when the destination X equals the own X.
- R3: When X matches and the Y coordinates differ, the port is +Y (code 3) when the destination Y is larger and -Y (code 4) when it is smaller.
- R4: When both coordinates match and the destination is in range, the port is local (code 0) and both hop fields are zero.
- R5: The hop field of the forwarded dimension equals its absolute offset minus one. The other hop field equals its own absolute offset.
- R6: A destination coordinate of RADIX or more in either dimension sets the error flag, selects the local port and zeroes both hop fields.
- R7: A header accepted on a clock edge (in_valid and in_ready both high) appears with out_valid high after that edge.
- R8: While out_valid is high and out_ready is low, the outputs hold their values and in_ready is low. When no result is pending, or the result is being taken, in_ready is high.
- R9: A packet forwarded hop by hop from a source to an in-range destination reaches the local port after exactly |dx|+|dy| hops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header can be taken |
| in_dst_x | input | CW | Destination X coordinate |
| in_dst_y | input | CW | Destination Y coordinate |
| own_x | input | CW | This switch's X coordinate |
| own_y | input | CW | This switch's Y coordinate |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Decision taken by the downstream logic |
| out_port | output | 3 | Port code: 0 local, 1 +X, 2 -X, 3 +Y, 4 -Y |
| out_hops_x | output | CW | Remaining X hops after this switch |
| out_hops_y | output | CW | Remaining Y hops after this switch |
| out_err | output | 1 | Destination out of range |

## Verification
The bench builds the block with RADIX of 5 and a 3-bit coordinate width. This makes the codes 5 to 7 representable, so the out-of-range path can be driven in both dimensions. The bench sweeps every in-range pair of source and destination. It walks packets across the mesh switch by switch to count the hops. It throttles out_ready both with a pseudo-random pattern and with a long stall, so the hold and back-pressure behaviour is exercised.

// File: rtl/dor_pkg.sv
package dor_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_XPOS  = 3'd1,
    PORT_XNEG  = 3'd2,
    PORT_YPOS  = 3'd3,
    PORT_YNEG  = 3'd4
  } port_e;
endpackage

// File: rtl/dor_axis.sv
module dor_axis #(
  parameter int CW = 3
) (
  input  logic [CW-1:0] dst,
  input  logic [CW-1:0] own,
  output logic          pos,
  output logic          nonzero,
  output logic [CW-1:0] mag
);
  always_comb begin
    pos     = dst > own;
    nonzero = dst != own;
    mag     = pos ? (dst - own) : (own - dst);
  end
endmodule

// File: rtl/dor_decide.sv
module dor_decide
  import dor_pkg::*;
#(
  parameter int RADIX = 5,
  parameter int CW    = 3
) (
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [1:0]    pos,
  input  logic [1:0]    nonzero,
  input  logic [CW-1:0] mag_x,
  input  logic [CW-1:0] mag_y,
  output port_e         port,
  output logic [CW-1:0] hops_x,
  output logic [CW-1:0] hops_y,
  output logic          err
);
  localparam logic [CW:0] LIMIT = (CW+1)'(RADIX);

  logic bad_x, bad_y;

  always_comb begin
    bad_x = {1'b0, dst_x} >= LIMIT;
    bad_y = {1'b0, dst_y} >= LIMIT;
    err    = bad_x | bad_y;
    port   = PORT_LOCAL;
    hops_x = '0;
    hops_y = '0;
    if (!err) begin
      if (nonzero[0]) begin
        port   = pos[0] ? PORT_XPOS : PORT_XNEG;
        hops_x = mag_x - CW'(1);
        hops_y = mag_y;
      end else if (nonzero[1]) begin
        port   = pos[1] ? PORT_YPOS : PORT_YNEG;
        hops_y = mag_y - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dor_stage.sv
module dor_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/dor_route_unit.sv
module dor_route_unit
  import dor_pkg::*;
#(
  parameter int RADIX = 5,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_dst_x,
  input  logic [CW-1:0] in_dst_y,
  input  logic [CW-1:0] own_x,
  input  logic [CW-1:0] own_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_port,
  output logic [CW-1:0] out_hops_x,
  output logic [CW-1:0] out_hops_y,
  output logic          out_err
);
  localparam int NDIM = 2;
  localparam int PW   = 1 + 3 + 2 * CW;

  logic [CW-1:0] dst_v [NDIM];
  logic [CW-1:0] own_v [NDIM];
  logic [CW-1:0] mag_v [NDIM];
  logic [NDIM-1:0] pos_v, nz_v;

  assign dst_v[0] = in_dst_x;
  assign dst_v[1] = in_dst_y;
  assign own_v[0] = own_x;
  assign own_v[1] = own_y;

  for (genvar d = 0; d < NDIM; d++) begin : g_axis
    dor_axis #(.CW(CW)) u_axis (
      .dst(dst_v[d]), .own(own_v[d]),
      .pos(pos_v[d]), .nonzero(nz_v[d]), .mag(mag_v[d])
    );
  end

  port_e         nx_port;
  logic [CW-1:0] nx_hx, nx_hy;
  logic          nx_err;

  dor_decide #(.RADIX(RADIX), .CW(CW)) u_decide (
    .dst_x(in_dst_x), .dst_y(in_dst_y),
    .pos(pos_v), .nonzero(nz_v),
    .mag_x(mag_v[0]), .mag_y(mag_v[1]),
    .port(nx_port), .hops_x(nx_hx), .hops_y(nx_hy), .err(nx_err)
  );

  logic [PW-1:0] pk_in, pk_out;
  assign pk_in = {nx_err, nx_port, nx_hx, nx_hy};

  dor_stage #(.W(PW)) u_stage (
    .clk(clk), .rst(rst),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(pk_in),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(pk_out)
  );

  assign {out_err, out_port, out_hops_x, out_hops_y} = pk_out;
endmodule

// File: rtl/dor_route_chk.sv
module dor_route_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [2:0]    out_port,
  input logic [CW-1:0] out_hops_x,
  input logic [CW-1:0] out_hops_y,
  input logic          out_err
);
  p_legal_port_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_port <= 3'd4);

  p_x_first_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_port == 3'd3 || out_port == 3'd4)) |-> out_hops_x == '0);

  p_local_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_port == 3'd0) |-> (out_hops_x == '0 && out_hops_y == '0));

  p_err_eject_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> out_port == 3'd0);

  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_port) &&
      $stable(out_hops_x) && $stable(out_hops_y) && $stable(out_err)));

  p_backpress_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind dor_route_unit dor_route_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port),
  .out_hops_x(out_hops_x), .out_hops_y(out_hops_y), .out_err(out_err)
);

// File: tb/dor_route_unit_tb.sv
module dor_route_unit_tb;
  localparam int RADIX = 5;
  localparam int CW    = 3;
  localparam int IW    = 1 + 3 + 2 * CW;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready;
  logic [CW-1:0] in_dst_x = 0, in_dst_y = 0, own_x = 0, own_y = 0;
  logic [2:0] out_port;
  logic [CW-1:0] out_hops_x, out_hops_y;
  logic out_err;

  int checks = 0, errors = 0, npop = 0;
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  logic [IW-1:0] exp_q [$];
  string tag_q [$];
  logic [IW-1:0] last_item;

  always #2.5 clk = ~clk;

  dor_route_unit #(.RADIX(RADIX), .CW(CW)) u_dut (.*);

  // out_ready changes just after each rising edge
  initial begin
    out_ready = 1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (rdy_mode)
        0: out_ready = 1;
        1: out_ready = 0;
        default: out_ready = lfsr[0] | lfsr[2];
      endcase
    end
  end

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  // Reference model written from the requirements
  function automatic logic [IW-1:0] model(int dx, int dy, int ox, int oy, output string tag);
    int rx, ry;
    logic [2:0] p;
    int hx, hy;
    rx = dx - ox; ry = dy - oy;
    if (dx >= RADIX || dy >= RADIX) begin
      tag = "R6"; return {1'b1, 3'd0, CW'(0), CW'(0)};
    end
    if (rx != 0) begin
      p = rx > 0 ? 3'd1 : 3'd2; hx = iabs(rx) - 1; hy = iabs(ry); tag = "R1/R5";
    end else if (ry != 0) begin
      p = ry > 0 ? 3'd3 : 3'd4; hx = 0; hy = iabs(ry) - 1; tag = "R2/R3/R5";
    end else begin
      p = 3'd0; hx = 0; hy = 0; tag = "R4";
    end
    return {1'b0, p, CW'(hx), CW'(hy)};
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(int dx, int dy, int ox, int oy);
    string t;
    @(negedge clk);
    in_dst_x = CW'(dx); in_dst_y = CW'(dy); own_x = CW'(ox); own_y = CW'(oy);
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(model(dx, dy, ox, oy, t));
    tag_q.push_back(t);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // Monitor: scoreboard compare on each output transfer
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid && out_ready) begin
        logic [IW-1:0] got;
        got = {out_err, out_port, out_hops_x, out_hops_y};
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected output", int'(got), 0);
        end else begin
          logic [IW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got === e, t, int'(got), int'(e));
        end
        last_item = got;
        npop++;
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [IW-1:0] held;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(out_valid == 0, "R7 reset out_valid", out_valid, 0);
    check(in_ready == 1, "R8 reset in_ready", in_ready, 1);

    // Full sweep of in-range pairs, downstream always ready
    for (int sx = 0; sx < RADIX; sx++)
      for (int sy = 0; sy < RADIX; sy++)
        for (int dx = 0; dx < RADIX; dx++)
          for (int dy = 0; dy < RADIX; dy++)
            send(dx, dy, sx, sy);
    drain();

    // R6: out-of-range destinations in each dimension
    send(5, 2, 1, 1); send(2, 7, 1, 1); send(6, 6, 0, 0); send(7, 0, 7, 0);
    drain();

    // R8: throttled downstream
    rdy_mode = 2;
    for (int i = 0; i < 60; i++) send((i * 3) % 8, (i * 5) % 6, (i * 7) % 5, i % 5);
    drain();

    // R7/R8: stall then release
    rdy_mode = 1;
    repeat (2) @(negedge clk);
    send(4, 0, 1, 3);
    @(negedge clk);
    check(out_valid == 1, "R7 registered result", out_valid, 1);
    held = {out_err, out_port, out_hops_x, out_hops_y};
    in_valid = 1; in_dst_x = 0; in_dst_y = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check({out_err, out_port, out_hops_x, out_hops_y} == held, "R8 hold",
            int'({out_err, out_port, out_hops_x, out_hops_y}), int'(held));
      check(in_ready == 0, "R8 backpressure", in_ready, 0);
    end
    in_valid = 0;
    rdy_mode = 0;
    drain();

    // R9: walk packets hop by hop across the mesh
    for (int k = 0; k < 6; k++) begin
      int cx, cy, tx, ty, hops, n0;
      cx = (k * 3) % RADIX; cy = (k * 2 + 4) % RADIX;
      tx = (k * 4 + 1) % RADIX; ty = k % RADIX;
      hops = 0;
      for (int step = 0; step < 4 * RADIX; step++) begin
        n0 = npop;
        send(tx, ty, cx, cy);
        while (npop == n0) @(negedge clk);
        case (last_item[2*CW +: 3])
          3'd1: cx++;
          3'd2: cx--;
          3'd3: cy++;
          3'd4: cy--;
          default: break;
        endcase
        hops++;
      end
      check(hops == iabs(tx - (k * 3) % RADIX) + iabs(ty - (k * 2 + 4) % RADIX),
            "R9 hop count", hops,
            iabs(tx - (k * 3) % RADIX) + iabs(ty - (k * 2 + 4) % RADIX));
    end
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule